// File: doc/BRIEF.md
# OR and Move Accumulator Execute Unit

This block is the single-cycle execute stage of a small accumulator-style processor. It holds an 8-bit working register, a 128-entry by 8-bit register file and a zero flag. Each cycle it accepts one operation that has already been decoded. The operation is given as a 3-bit select, an 8-bit literal, a 7-bit register address and a destination bit. A valid strobe qualifies the operation.

Six operations are supported: OR a literal into the working register, OR the working register with a file register, move a file register, load a literal, store the working register, and no-operation. For the two operations that read a file register, the destination bit picks the target. When it is 0 the result goes to the working register; when it is 1 the result is written back to the addressed register. Only the OR operations and the move-from-file operation update the zero flag. Moving a register onto itself therefore acts as a zero test.

A second, independent read port lets a testbench or debugger look at any register file entry without disturbing execution.

Top module: `acc_or_mov_unit`

## Requirements
- R1: While rst_ni is low, the working register, the zero flag and all 128 file registers are cleared to 0x00 / 0.
- R2: With op_i = 1 (OR literal), the working register becomes W | lit_i on the next clock edge.
- R3: With op_i = 2 and dest_i = 0, the working register becomes W | f[addr_i], and f[addr_i] is unchanged.
- R4: With op_i = 2 and dest_i = 1, f[addr_i] becomes W | f[addr_i], and the working register is unchanged.
- R5: With op_i = 3 and dest_i = 0, the working register becomes f[addr_i].
- R6: With op_i = 3 and dest_i = 1, f[addr_i] keeps its value, the working register is unchanged, and the zero flag reports whether f[addr_i] is 0x00.
- R7: With op_i = 4 (load literal), the working register becomes lit_i, and the zero flag is unchanged.
- R8: With op_i = 5 (store), f[addr_i] becomes W, and the working register and zero flag are unchanged.
- R9: op_i = 0 (no-operation) and the unused codes 6 and 7 change no register and no flag.
- R10: While valid_i is low, no register and no flag changes, whatever the other inputs are.
- R11: For op_i = 1, 2 and 3, the zero flag is set when the 8-bit result is 0x00 and cleared otherwise. It is written on the same edge as the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies the operation presented this cycle |
| op_i | input | 3 | Operation select (0 nop, 1 or-lit, 2 or-reg, 3 mov-reg, 4 mov-lit, 5 store) |
| lit_i | input | 8 | Literal operand |
| addr_i | input | 7 | Register file address |
| dest_i | input | 1 | 0: result to working register, 1: result to file register |
| w_o | output | 8 | Working register |
| zero_o | output | 1 | Zero flag |
| dbg_addr_i | input | 7 | Debug read address |
| dbg_data_o | output | 8 | Register file contents at dbg_addr_i |

## Verification
All 128 addresses are first filled with a computed pattern that contains zero entries. Each address is then taken through OR-to-W, OR-to-file, move-to-W and move-in-place. This separates the two destinations and exposes a write that lands in the wrong place. Every literal from 0 to 255 is loaded and then ORed with a second computed literal. These pairs include pairs whose OR is zero, and they show that a literal load leaves the zero flag alone. All eight select codes are also applied with the strobe low, and the unused codes with the strobe high, to show that nothing changes.

// File: rtl/acc_or_mov_pkg.sv
package acc_or_mov_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_OR_LIT  = 3'd1,
    OP_OR_REG  = 3'd2,
    OP_MOV_REG = 3'd3,
    OP_MOV_LIT = 3'd4,
    OP_STORE   = 3'd5
  } op_e;
endpackage

// File: rtl/acc_or_mov_alu.sv
module acc_or_mov_alu
  import acc_or_mov_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic              dest_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] f_i,
  input  logic [DATA_W-1:0] lit_i,
  output logic [DATA_W-1:0] res_o,
  output logic              w_we_o,
  output logic              f_we_o,
  output logic              z_we_o
);
  always_comb begin
    res_o  = '0;
    w_we_o = 1'b0;
    f_we_o = 1'b0;
    z_we_o = 1'b0;
    case (op_e'(op_i))
      OP_OR_LIT: begin
        res_o  = w_i | lit_i;
        w_we_o = 1'b1;
        z_we_o = 1'b1;
      end
      OP_OR_REG: begin
        res_o  = w_i | f_i;
        w_we_o = !dest_i;
        f_we_o = dest_i;
        z_we_o = 1'b1;
      end
      OP_MOV_REG: begin
        res_o  = f_i;
        w_we_o = !dest_i;
        f_we_o = dest_i;
        z_we_o = 1'b1;
      end
      OP_MOV_LIT: begin
        res_o  = lit_i;
        w_we_o = 1'b1;
      end
      OP_STORE: begin
        res_o  = w_i;
        f_we_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_or_mov_rf.sv
module acc_or_mov_rf #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o    = mem_q[addr_i];
  assign dbg_data_o = mem_q[dbg_addr_i];
endmodule

// File: rtl/acc_or_mov_unit.sv
module acc_or_mov_unit #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] lit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dest_i,
  output logic [DATA_W-1:0] w_o,
  output logic              zero_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  logic [DATA_W-1:0] w_q;
  logic              z_q;
  logic [DATA_W-1:0] f_rd;
  logic [DATA_W-1:0] res;
  logic              w_we, f_we, z_we;

  acc_or_mov_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (op_i),
    .dest_i (dest_i),
    .w_i    (w_q),
    .f_i    (f_rd),
    .lit_i  (lit_i),
    .res_o  (res),
    .w_we_o (w_we),
    .f_we_o (f_we),
    .z_we_o (z_we)
  );

  acc_or_mov_rf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (valid_i && f_we),
    .addr_i     (addr_i),
    .wdata_i    (res),
    .rdata_o    (f_rd),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q <= '0;
      z_q <= 1'b0;
    end else if (valid_i) begin
      if (w_we) w_q <= res;
      if (z_we) z_q <= (res == '0);
    end
  end

  assign w_o    = w_q;
  assign zero_o = z_q;
endmodule

// File: rtl/acc_or_mov_unit_chk.sv
module acc_or_mov_unit_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] lit_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              dest_i,
  input logic [DATA_W-1:0] w_o,
  input logic              zero_o
);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(w_o) && $stable(zero_o)));

  // R2
  or_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1) |=> (w_o == ($past(w_o) | $past(lit_i))));

  // R11
  or_lit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1) |=> (zero_o == (w_o == '0)));

  // R3
  or_reg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && !dest_i) |=> (zero_o == (w_o == '0)));

  // R4
  or_reg_keep_w_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && dest_i) |=> $stable(w_o));

  // R6
  mov_self_keep_w_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && dest_i) |=> $stable(w_o));

  // R7
  mov_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (w_o == $past(lit_i) && $stable(zero_o)));

  // R8
  store_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd5) |=> ($stable(w_o) && $stable(zero_o)));

  // R9
  nop_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd0 || op_i > 3'd5)) |=> ($stable(w_o) && $stable(zero_o)));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_clear_chk: assert (w_o == '0 && !zero_o);
    end
  end
endmodule

bind acc_or_mov_unit acc_or_mov_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/acc_or_mov_unit_test.sv
module acc_or_mov_unit_test;
  localparam int DW    = 8;
  localparam int AW    = 7;
  localparam int DEPTH = 2 ** AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [DW-1:0] lit_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic          dest_i = 1'b0;
  logic [DW-1:0] w_o;
  logic          zero_o;
  logic [AW-1:0] dbg_addr_i = '0;
  logic [DW-1:0] dbg_data_o;

  int vectors = 0;
  int fails   = 0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_w;
  logic          m_z;

  always #5ns clk_i = ~clk_i;

  acc_or_mov_unit #(.DATA_W(DW), .ADDR_W(AW)) uut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drives one operation, updates the model, checks W, Z and f[a] after the edge
  task automatic apply(input logic v, input logic [2:0] op, input logic [DW-1:0] k,
                       input logic [AW-1:0] a, input logic d, input string req);
    logic [DW-1:0] r;
    @(negedge clk_i);
    valid_i = v; op_i = op; lit_i = k; addr_i = a; dest_i = d;
    if (v) begin
      case (op)
        3'd1: begin r = m_w | k; m_w = r; m_z = (r == 0); end
        3'd2: begin r = m_w | m_mem[a]; if (d) m_mem[a] = r; else m_w = r; m_z = (r == 0); end
        3'd3: begin r = m_mem[a]; if (!d) m_w = r; m_z = (r == 0); end
        3'd4: m_w = k;
        3'd5: m_mem[a] = m_w;
        default: ;
      endcase
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    dbg_addr_i = a;
    #1;
    chk(req, "w", int'(w_o), int'(m_w));
    chk(req, "zero", int'(zero_o), int'(m_z));
    chk(req, "file", int'(dbg_data_o), int'(m_mem[a]));
  endtask

  task automatic sweep_file(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      dbg_addr_i = AW'(i);
      #1;
      chk(req, "file sweep", int'(dbg_data_o), int'(m_mem[i]));
    end
  endtask

  initial begin
    m_w = '0;
    m_z = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    // scribble the inputs during reset: nothing may stick
    repeat (3) @(negedge clk_i);
    valid_i = 1'b1; op_i = 3'd4; lit_i = 8'hA5;
    @(negedge clk_i);
    valid_i = 1'b0;
    #1;
    chk("R1", "w in reset", int'(w_o), 0);
    chk("R1", "zero in reset", int'(zero_o), 0);
    sweep_file("R1");
    rst_ni = 1'b1;

    // fill the file with a pattern that has zero entries (R7, R8)
    for (int i = 0; i < DEPTH; i++) begin
      logic [DW-1:0] p;
      p = (i % 9 == 0) ? 8'h00 : DW'((i * 37 + 5) & 8'hFF);
      apply(1'b1, 3'd4, p, AW'(i), 1'b0, "R7");
      apply(1'b1, 3'd5, 8'h00, AW'(i), 1'b0, "R8");
    end
    sweep_file("R8");

    // per-address moves and ORs
    for (int i = 0; i < DEPTH; i++) begin
      apply(1'b1, 3'd3, 8'h00, AW'(i), 1'b1, "R6");
      apply(1'b1, 3'd3, 8'h00, AW'(i), 1'b0, "R5");
      apply(1'b1, 3'd4, DW'((i * 3) & 8'h0F), AW'(i), 1'b0, "R7");
      apply(1'b1, 3'd2, 8'h00, AW'(i), 1'b0, "R3");
      apply(1'b1, 3'd4, DW'(i & 8'h30), AW'(i), 1'b0, "R7");
      apply(1'b1, 3'd2, 8'h00, AW'(i), 1'b1, "R4");
      apply(1'b1, 3'd3, 8'h00, AW'(i), 1'b1, "R11");
    end
    sweep_file("R4");

    // OR literal against every literal, zero cases included
    for (int k = 0; k < 256; k++) begin
      apply(1'b1, 3'd4, DW'(k), 7'd0, 1'b0, "R7");
      apply(1'b1, 3'd1, DW'((k * 7) & ((k < 64) ? 8'h00 : 8'hFF)), 7'd0, 1'b0, "R2");
      apply(1'b1, 3'd1, 8'h00, 7'd0, 1'b0, "R11");
    end

    // strobe low: every op code, nothing changes
    apply(1'b1, 3'd4, 8'h3C, 7'd5, 1'b0, "R7");
    for (int op = 0; op < 8; op++) begin
      for (int d = 0; d < 2; d++) begin
        apply(1'b0, 3'(op), 8'hC3, AW'(op * 11), d[0], "R10");
      end
    end
    // nop and unused codes with the strobe high
    for (int op = 6; op < 9; op++) begin
      for (int d = 0; d < 2; d++) begin
        apply(1'b1, 3'(op % 8), 8'hFF, AW'(op * 13), d[0], "R9");
      end
    end
    apply(1'b1, 3'd1, 8'h00, 7'd0, 1'b0, "R11");
    sweep_file("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1500us;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule